// File: doc/BRIEF.md
# Strobe Edge Status Flag with Two-Step Clear

This block watches an asynchronous strobe pin and raises a sticky status flag each time the pin makes the selected transition. A control bit picks either rising or falling transitions as the active edge. The flag drives a maskable interrupt request. The pin is brought into the clock domain by a parameterised synchroniser, and a one-level history register detects the edge.

Software can clear the flag only with a two-step sequence. First, reading the status register while the flag is set arms the clear. Second, an access to the data latch register clears the flag. That access is a latch read in the simple strobe and input handshake modes, and a latch write in the output handshake mode. The mode bits present in the cycle of that access decide which access counts. Any new selected edge disarms the sequence, so a set flag cannot be lost to a stale clear.

Top module: `strobe_edge_flag`

## Requirements
- R1: After reset, `flag_o`, `armed_o` and `irq_o` are 0.
- R2: With `edge_rise_sel`=1, a 0-to-1 change on `strobe_in` sets the flag and a 1-to-0 change leaves it unchanged.
- R3: With `edge_rise_sel`=0, a 1-to-0 change on `strobe_in` sets the flag and a 0-to-1 change leaves it unchanged.
- R4: A strobe change first sampled at one rising clock edge shows on `flag_o` after the (SYNC_STAGES+1)-th rising clock edge counted from that one. With the default of 2, that is the third edge.
- R5: A `stat_rd` pulse while `flag_o`=1 sets `armed_o` at the next clock edge. A `stat_rd` pulse while `flag_o`=0 does not arm.
- R6: When armed and not in output handshake mode (`hs_en`=0, or `hs_en`=1 with `dir_out`=0), a `latch_rd` pulse clears both the flag and the arm at the next clock edge. In that case a `latch_wr` pulse has no effect.
- R7: When armed in output handshake mode (`hs_en`=1, `dir_out`=1), a `latch_wr` pulse clears the flag and the arm. In that mode a `latch_rd` pulse has no effect.
- R8: The mode bits in the cycle of the latch access decide which access clears, whatever the mode was when the flag was armed.
- R9: The arm persists for any number of cycles until a clear or a selected edge.
- R10: A selected edge detected while armed removes the arm, and a later latch access then leaves the flag set.
- R11: If a selected edge and a valid clearing access are seen in the same cycle, the flag stays 1 and the arm goes to 0.
- R12: `irq_o` is 1 exactly when `flag_o`=1 and `irq_en`=1.
- R13: A latch access without a prior arm never clears the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strobe_in | input | 1 | Raw asynchronous strobe pin |
| edge_rise_sel | input | 1 | 1 selects rising edges, 0 selects falling edges |
| irq_en | input | 1 | Interrupt enable |
| hs_en | input | 1 | Handshake mode enable |
| dir_out | input | 1 | With hs_en=1, 1 selects output handshake |
| stat_rd | input | 1 | One-cycle status register read strobe |
| latch_rd | input | 1 | One-cycle latch register read strobe |
| latch_wr | input | 1 | One-cycle latch register write strobe |
| flag_o | output | 1 | Edge status flag |
| armed_o | output | 1 | Clear sequence armed |
| irq_o | output | 1 | Interrupt request |

## Verification
Two functions can land on the same clock edge: a freshly detected selected edge and the second step of an armed clear. The bench arms the flag, then toggles the strobe. It places a `latch_rd` pulse in exactly the cycle where the synchronised edge is evaluated, two clock edges after the strobe change is sampled. The result is judged correct only if the flag is still 1 and the arm is 0 afterwards. A design that gives the clear priority would lose the new event.

// File: rtl/sef_pkg.sv
package sef_pkg;

   typedef enum logic [1:0] {
      SEF_SIMPLE = 2'd0,
      SEF_HS_IN  = 2'd1,
      SEF_HS_OUT = 2'd2
   } sef_mode_e;

   function automatic sef_mode_e sef_decode(input logic hs, input logic dir);
      if (!hs)     return SEF_SIMPLE;
      else if (dir) return SEF_HS_OUT;
      else         return SEF_HS_IN;
   endfunction

   // which latch access completes the clear in the given mode
   function automatic logic sef_second_step(input sef_mode_e m,
                                            input logic rd,
                                            input logic wr);
      return (m == SEF_HS_OUT) ? wr : rd;
   endfunction

endpackage

// File: rtl/sef_sync.sv
module sef_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain;

   generate
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[0] <= 1'b0;
               else        chain[0] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[i] <= 1'b0;
               else        chain[i] <= chain[i-1];
            end
         end
      end
   endgenerate

   assign q = chain[STAGES-1];
endmodule

// File: rtl/sef_edge_det.sv
module sef_edge_det (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl,
   input  logic rise_sel,
   output logic hit
);
   logic prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= 1'b0;
      else        prev <= lvl;
   end

   always_comb begin
      if (rise_sel) hit = lvl & ~prev;
      else          hit = ~lvl & prev;
   end
endmodule

// File: rtl/sef_flag_ctl.sv
module sef_flag_ctl (
   input  logic clk,
   input  logic rst_n,
   input  logic edge_hit,
   input  logic stat_rd,
   input  logic step_two,
   output logic flag,
   output logic armed
);
   logic clr_hit;

   assign clr_hit = armed & step_two;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag  <= 1'b0;
         armed <= 1'b0;
      end else begin
         // a new edge always wins over a clear and cancels the arm
         if (edge_hit) begin
            flag  <= 1'b1;
            armed <= 1'b0;
         end else if (clr_hit) begin
            flag  <= 1'b0;
            armed <= 1'b0;
         end else if (stat_rd && flag) begin
            armed <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/strobe_edge_flag.sv
module strobe_edge_flag #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic strobe_in,
   input  logic edge_rise_sel,
   input  logic irq_en,
   input  logic hs_en,
   input  logic dir_out,
   input  logic stat_rd,
   input  logic latch_rd,
   input  logic latch_wr,
   output logic flag_o,
   output logic armed_o,
   output logic irq_o
);
   import sef_pkg::*;

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("strobe_edge_flag: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic      strobe_s;
   logic      edge_hit;
   logic      step_two;
   sef_mode_e mode;

   sef_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (strobe_in),
      .q     (strobe_s)
   );

   sef_edge_det u_edge (
      .clk      (clk),
      .rst_n    (rst_n),
      .lvl      (strobe_s),
      .rise_sel (edge_rise_sel),
      .hit      (edge_hit)
   );

   assign mode     = sef_decode(hs_en, dir_out);
   assign step_two = sef_second_step(mode, latch_rd, latch_wr);

   sef_flag_ctl u_ctl (
      .clk      (clk),
      .rst_n    (rst_n),
      .edge_hit (edge_hit),
      .stat_rd  (stat_rd),
      .step_two (step_two),
      .flag     (flag_o),
      .armed    (armed_o)
   );

   assign irq_o = flag_o & irq_en;
endmodule

// File: rtl/strobe_edge_flag_chk.sv
module strobe_edge_flag_chk (
   input logic clk,
   input logic rst_n,
   input logic edge_hit,
   input logic irq_en,
   input logic hs_en,
   input logic dir_out,
   input logic stat_rd,
   input logic latch_rd,
   input logic latch_wr,
   input logic flag_o,
   input logic armed_o,
   input logic irq_o
);
   AST_ARM_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      armed_o |-> flag_o);                                               // R5
   AST_ARM_FROM_READ: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(armed_o) |-> ($past(stat_rd) && $past(flag_o)));             // R5
   AST_CLEAR_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flag_o) |-> $past(armed_o));                                 // R13
   AST_CLEAR_BY_MODE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flag_o) |-> ($past(hs_en && dir_out) ? $past(latch_wr) : $past(latch_rd))); // R8
   AST_SET_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      edge_hit |=> flag_o);                                              // R11
   AST_EDGE_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
      edge_hit |=> !armed_o);                                            // R10
   AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_en |-> !irq_o);                                               // R12
endmodule

bind strobe_edge_flag strobe_edge_flag_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .edge_hit (edge_hit),
   .irq_en   (irq_en),
   .hs_en    (hs_en),
   .dir_out  (dir_out),
   .stat_rd  (stat_rd),
   .latch_rd (latch_rd),
   .latch_wr (latch_wr),
   .flag_o   (flag_o),
   .armed_o  (armed_o),
   .irq_o    (irq_o)
);

// File: tb/strobe_edge_flag_tb_top.sv
`timescale 1ns/1ps
module strobe_edge_flag_tb_top;
   localparam real CLK_PERIOD = 20.0;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic strobe_in = 1'b0, edge_rise_sel = 1'b1, irq_en = 1'b0;
   logic hs_en = 1'b0, dir_out = 1'b0;
   logic stat_rd = 1'b0, latch_rd = 1'b0, latch_wr = 1'b0;
   logic flag_o, armed_o, irq_o;

   int checks = 0;
   int failures = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   strobe_edge_flag dut_i (
      .clk(clk), .rst_n(rst_n), .strobe_in(strobe_in),
      .edge_rise_sel(edge_rise_sel), .irq_en(irq_en),
      .hs_en(hs_en), .dir_out(dir_out), .stat_rd(stat_rd),
      .latch_rd(latch_rd), .latch_wr(latch_wr),
      .flag_o(flag_o), .armed_o(armed_o), .irq_o(irq_o)
   );

   task automatic check(input string req, input string what,
                        input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
      end
   endtask

   task automatic set_strobe(input logic v);
      @(negedge clk) strobe_in = v;
      repeat (4) @(negedge clk);
   endtask

   task automatic make_edge();
      set_strobe(~edge_rise_sel);
      set_strobe(edge_rise_sel);
   endtask

   task automatic pulse_stat();
      @(negedge clk) stat_rd = 1'b1;
      @(negedge clk) stat_rd = 1'b0;
   endtask

   task automatic pulse_rd();
      @(negedge clk) latch_rd = 1'b1;
      @(negedge clk) latch_rd = 1'b0;
   endtask

   task automatic pulse_wr();
      @(negedge clk) latch_wr = 1'b1;
      @(negedge clk) latch_wr = 1'b0;
   endtask

   task automatic clear_simple();
      hs_en = 1'b0; dir_out = 1'b0;
      pulse_stat();
      pulse_rd();
   endtask

   task automatic t_reset();
      check("R1", "flag after reset", flag_o, 1'b0);
      check("R1", "armed after reset", armed_o, 1'b0);
      check("R1", "irq after reset", irq_o, 1'b0);
   endtask

   task automatic t_rising();
      edge_rise_sel = 1'b1;
      @(negedge clk) strobe_in = 1'b1;
      @(negedge clk);
      check("R4", "flag after 1st edge", flag_o, 1'b0);
      @(negedge clk);
      check("R4", "flag after 2nd edge", flag_o, 1'b0);
      @(negedge clk);
      check("R4", "flag after 3rd edge", flag_o, 1'b1);
      check("R2", "rising sets flag", flag_o, 1'b1);
      clear_simple();
      check("R6", "simple clear by latch read", flag_o, 1'b0);
      set_strobe(1'b0);
      check("R2", "falling ignored", flag_o, 1'b0);
   endtask

   task automatic t_falling();
      edge_rise_sel = 1'b0;
      set_strobe(1'b1);
      check("R3", "rising ignored", flag_o, 1'b0);
      set_strobe(1'b0);
      check("R3", "falling sets flag", flag_o, 1'b1);
      clear_simple();
      check("R3", "cleared", flag_o, 1'b0);
   endtask

   task automatic t_arm_simple();
      pulse_stat();
      check("R5", "no arm with flag 0", armed_o, 1'b0);
      make_edge();
      pulse_rd();
      check("R13", "unarmed read keeps flag", flag_o, 1'b1);
      pulse_stat();
      check("R5", "arm with flag 1", armed_o, 1'b1);
      pulse_wr();
      check("R6", "write ignored in simple mode", flag_o, 1'b1);
      check("R6", "arm kept after write", armed_o, 1'b1);
      pulse_rd();
      check("R6", "read clears flag", flag_o, 1'b0);
      check("R6", "read clears arm", armed_o, 1'b0);
   endtask

   task automatic t_out_mode();
      hs_en = 1'b1; dir_out = 1'b1;
      make_edge();
      pulse_stat();
      pulse_rd();
      check("R7", "read ignored in output mode", flag_o, 1'b1);
      pulse_wr();
      check("R7", "write clears in output mode", flag_o, 1'b0);
      check("R7", "arm removed", armed_o, 1'b0);
   endtask

   task automatic t_mode_switch();
      hs_en = 1'b1; dir_out = 1'b0;
      make_edge();
      pulse_stat();
      dir_out = 1'b1;
      pulse_rd();
      check("R8", "read after switch to output", flag_o, 1'b1);
      pulse_wr();
      check("R8", "write after switch clears", flag_o, 1'b0);
      dir_out = 1'b0;
      make_edge();
      pulse_stat();
      pulse_rd();
      check("R6", "input handshake read clears", flag_o, 1'b0);
   endtask

   task automatic t_long_wait();
      hs_en = 1'b0; dir_out = 1'b0;
      make_edge();
      pulse_stat();
      repeat (200) @(negedge clk);
      check("R9", "arm held 200 cycles", armed_o, 1'b1);
      pulse_rd();
      check("R9", "late clear works", flag_o, 1'b0);
   endtask

   task automatic t_edge_disarm();
      make_edge();
      pulse_stat();
      make_edge();
      check("R10", "edge removes arm", armed_o, 1'b0);
      pulse_rd();
      check("R10", "stale clear ignored", flag_o, 1'b1);
      clear_simple();
   endtask

   task automatic t_same_cycle();
      edge_rise_sel = 1'b1;
      set_strobe(1'b0);
      make_edge();
      set_strobe(1'b0);
      pulse_stat();
      @(negedge clk) strobe_in = 1'b1;
      @(negedge clk);
      @(negedge clk) latch_rd = 1'b1;
      @(negedge clk) latch_rd = 1'b0;
      check("R11", "flag kept on collision", flag_o, 1'b1);
      check("R11", "arm dropped on collision", armed_o, 1'b0);
      repeat (3) @(negedge clk);
   endtask

   task automatic t_irq();
      irq_en = 1'b0;
      @(negedge clk);
      check("R12", "irq masked", irq_o, 1'b0);
      irq_en = 1'b1;
      @(negedge clk);
      check("R12", "irq with flag and enable", irq_o, 1'b1);
      clear_simple();
      check("R12", "irq drops with flag", irq_o, 1'b0);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      if (!finished) begin
         failures++;
         $display("FAIL watchdog expired actual=hung expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_rising();
      t_falling();
      edge_rise_sel = 1'b1;
      set_strobe(1'b0);
      t_arm_simple();
      t_out_mode();
      t_mode_switch();
      t_long_wait();
      t_edge_disarm();
      t_same_cycle();
      t_irq();
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule